// File: doc/BRIEF.md
# Prescaled Periodic Interval Timer

This block raises a periodic interrupt for a processor core. A 16-bit down-counter steps once for every N core clock cycles, where N is one more than the value held in an 8-bit scale register. When a step finds the counter at zero, the block pulses its interrupt output for one cycle and refills the counter from a 16-bit period register. Software therefore sets the interrupt interval to (scale + 1) × (period + 1) clock cycles.

Three registers sit behind a simple write port and a combinational read port: the scale register at address 0, the live count at address 1 and the period register at address 2. A write to the scale register also restarts the prescaler from the new value. A level enable input freezes or runs the whole timer, and counting resumes from whatever value the count register holds.

Top module: `interval_timer`

## Requirements
- R1: After reset the scale, count and period registers read as 0 and the interrupt output is low.
- R2: A write with `wr_en` high stores `wr_data` into the register chosen by `wr_addr` (0 = scale, low 8 bits; 1 = count; 2 = period) at the clock edge. `rd_data` shows the register chosen by `rd_addr` combinationally, with the scale value zero-extended. Address 3 reads as 0.
- R3: While enabled, the count steps down once every scale + 1 cycles. A scale write reloads the prescaler, so the first step falls scale cycles after the write.
- R4: A step that finds the count at 0 drives `irq` high for exactly that one cycle, and at the next edge the count becomes the period value.
- R5: With steady settings the interrupts repeat every (scale + 1) × (period + 1) cycles. The first interrupt comes (count + 1) × (scale + 1) − 1 cycles after enable rises. A period of 0 gives an interrupt on every step.
- R6: While `enable` is low, the prescaler and the count keep their values and `irq` stays low.
- R7: A count write takes effect at the next edge and wins over a step or reload in the same cycle. The interrupt of that cycle is suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run (1) or freeze (0) the timer |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for writes |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Register select for reads |
| rd_data | output | 16 | Read data |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest case to reach from the ports is a count write that lands in the very cycle where a step finds the counter at zero. Reaching it requires knowing exactly when the reload would happen. The bench creates this cycle on purpose: it preloads a count of 0 with scale 0 while the timer is frozen. It then raises enable and writes the count in the same cycle, so a tick meets a zero count together with the override. The bench checks that `irq` stays low in that cycle and that the written value survives.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  typedef enum logic [1:0] {
    ITMR_SCALE  = 2'd0,
    ITMR_COUNT  = 2'd1,
    ITMR_PERIOD = 2'd2,
    ITMR_NONE   = 2'd3
  } itmr_reg_e;
endpackage

// File: rtl/itmr_regs.sv
module itmr_regs
  import itmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SCL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  input  logic [CNT_W-1:0] count_i,
  output logic [SCL_W-1:0] scale_o,
  output logic [CNT_W-1:0] period_o,
  output logic             scale_wr_o,
  output logic             count_wr_o,
  output logic [CNT_W-1:0] rd_data
);
  logic period_wr;

  assign scale_wr_o = wr_en && (itmr_reg_e'(wr_addr) == ITMR_SCALE);
  assign count_wr_o = wr_en && (itmr_reg_e'(wr_addr) == ITMR_COUNT);
  assign period_wr  = wr_en && (itmr_reg_e'(wr_addr) == ITMR_PERIOD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scale_o  <= '0;
      period_o <= '0;
    end else begin
      if (scale_wr_o) scale_o  <= wr_data[SCL_W-1:0];
      if (period_wr)  period_o <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (itmr_reg_e'(rd_addr))
      ITMR_SCALE:  rd_data[SCL_W-1:0] = scale_o;
      ITMR_COUNT:  rd_data = count_i;
      ITMR_PERIOD: rd_data = period_o;
      default:     rd_data = '0;
    endcase
  end

  assert_period_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    period_wr |=> period_o == $past(wr_data));
endmodule

// File: rtl/itmr_prescaler.sv
module itmr_prescaler #(
  parameter int SCL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [SCL_W-1:0] scale,
  input  logic             scale_wr,
  input  logic [SCL_W-1:0] scale_new,
  output logic             tick
);
  logic [SCL_W-1:0] presc_q;

  function automatic logic [SCL_W-1:0] next_presc(input logic [SCL_W-1:0] cur,
                                                   input logic [SCL_W-1:0] reload);
    return (cur == '0) ? reload : cur - 1'b1;
  endfunction

  assign tick = enable && (presc_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)        presc_q <= '0;
    else if (scale_wr) presc_q <= scale_new;
    else if (enable)   presc_q <= next_presc(presc_q, scale);
  end

  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (scale != '0) && !scale_wr |=> !tick);
  assert_presc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !scale_wr |=> $stable(presc_q));
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  input  logic             count_wr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_o,
  output logic             reload
);
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                   input logic [CNT_W-1:0] per);
    return (cur == '0) ? per : cur - 1'b1;
  endfunction

  assign reload = tick && (count_o == '0) && !count_wr;

  always_ff @(posedge clk) begin
    if (!rst_n)        count_o <= '0;
    else if (count_wr) count_o <= wr_data;
    else if (tick)     count_o <= next_count(count_o, period);
  end

  assert_reload_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> count_o == $past(period));
  assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reload && (period != '0) |=> !reload);
  assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !count_wr |=> $stable(count_o));
  assert_wr_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count_wr |=> count_o == $past(wr_data));
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int CNT_W = 16,
  parameter int SCL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq
);
  logic [SCL_W-1:0] scale;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] count;
  logic             scale_wr;
  logic             count_wr;
  logic             tick;

  itmr_regs #(.CNT_W(CNT_W), .SCL_W(SCL_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .count_i(count),
    .scale_o(scale), .period_o(period), .scale_wr_o(scale_wr),
    .count_wr_o(count_wr), .rd_data(rd_data)
  );

  itmr_prescaler #(.SCL_W(SCL_W)) presc_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scale(scale),
    .scale_wr(scale_wr), .scale_new(wr_data[SCL_W-1:0]), .tick(tick)
  );

  itmr_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .period(period),
    .count_wr(count_wr), .wr_data(wr_data), .count_o(count), .reload(irq)
  );

  assert_no_irq_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !irq);
endmodule

// File: tb/interval_timer_tb_top.sv
module interval_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  interval_timer dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output int v);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic test_reset;
    int v;
    reg_read(2'd0, v); check("R1 scale", v, 0);
    reg_read(2'd1, v); check("R1 count", v, 0);
    reg_read(2'd2, v); check("R1 period", v, 0);
    check("R1 irq", int'(irq), 0);
  endtask

  task automatic test_regs;
    int v;
    reg_write(2'd0, 16'hABCD);
    reg_write(2'd1, 16'h1234);
    reg_write(2'd2, 16'hBEEF);
    reg_read(2'd0, v); check("R2 scale low byte", v, 'hCD);
    reg_read(2'd1, v); check("R2 count", v, 'h1234);
    reg_read(2'd2, v); check("R2 period", v, 'hBEEF);
    reg_read(2'd3, v); check("R2 unused address", v, 0);
  endtask

  // R3 R4 R5: irq positions measured from enable rising
  task automatic test_irq(input int s, input int p, input int c, input int span, input string tag);
    int first, intv, bad, seen, v;
    enable = 1'b0;
    reg_write(2'd2, 16'(p));
    reg_write(2'd1, 16'(c));
    reg_write(2'd0, 16'(s));
    first = (c + 1) * (s + 1) - 1;
    intv  = (s + 1) * (p + 1);
    bad = 0; seen = 0;
    enable = 1'b1;
    for (int k = 0; k < span; k++) begin
      logic exp_irq;
      exp_irq = (k >= first) && (((k - first) % intv) == 0);
      #1;
      if (irq !== exp_irq) bad++;
      if (irq) seen++;
      @(negedge clk);
    end
    enable = 1'b0;
    check({tag, " irq cycle mismatches"}, bad, 0);
    check({tag, " irq count"}, seen, (span - 1 - first) / intv + 1);
    reg_read(2'd1, v);
    v = v;
  endtask

  task automatic test_step_rate;
    int v;
    enable = 1'b0;
    reg_write(2'd1, 16'd100);
    reg_write(2'd0, 16'd3);
    enable = 1'b1;
    repeat (8) @(negedge clk);
    enable = 1'b0;
    reg_read(2'd1, v);
    check("R3 two steps in 8 cycles at scale 3", v, 98);
  endtask

  task automatic test_hold;
    int v1, v2, pulses;
    enable = 1'b0;
    reg_write(2'd2, 16'd0);
    reg_write(2'd1, 16'd50);
    reg_write(2'd0, 16'd1);
    enable = 1'b1;
    repeat (10) @(negedge clk);
    enable = 1'b0;
    reg_read(2'd1, v1);
    check("R6 count before freeze", v1, 45);
    pulses = 0;
    repeat (20) begin
      #1 if (irq) pulses++;
      @(negedge clk);
    end
    reg_read(2'd1, v2);
    check("R6 count frozen", v2, v1);
    check("R6 no irq while frozen", pulses, 0);
    enable = 1'b1;
    repeat (2) @(negedge clk);
    enable = 1'b0;
    reg_read(2'd1, v2);
    check("R6 prescaler phase kept", v2, 44);
  endtask

  task automatic test_override;
    int v;
    enable = 1'b0;
    reg_write(2'd2, 16'd5);
    reg_write(2'd1, 16'd9);
    reg_write(2'd0, 16'd0);
    enable = 1'b1;
    repeat (3) @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'd40;
    @(negedge clk);
    wr_en = 1'b0;
    reg_read(2'd1, v); check("R7 write beats step", v, 40);
    @(negedge clk);
    reg_read(2'd1, v); check("R7 counting resumes", v, 39);
    enable = 1'b0;
    reg_write(2'd1, 16'd0);
    @(negedge clk);
    enable = 1'b1;
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'd10;
    #1 check("R7 irq suppressed on write", int'(irq), 0);
    @(negedge clk);
    wr_en = 1'b0; enable = 1'b0;
    reg_read(2'd1, v); check("R7 write beats reload", v, 10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_regs();
    test_step_rate();
    test_irq(0, 3, 2, 30, "R4 R5 scale0 period3");
    test_irq(2, 1, 0, 40, "R3 R5 scale2 period1");
    test_irq(0, 0, 0, 12, "R5 period0");
    test_irq(4, 2, 1, 60, "R5 scale4 period2");
    test_hold();
    test_override();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule